// File: doc/BRIEF.md
# Serial Word Memory Controller

This block is a small word-organised memory of 32 entries of 16 bits, reached over a five-line serial bus. The lines are a shift clock, a serial data input, a receive-enable, a serial data output and a busy indication. The bus lines are sampled by the system clock, which is much faster than the bus clock. A host first enables receive and clocks in a control word. The control word carries the word address, a start-half bit, a two-bit instruction and, in the long format, chip-select bits. When receive-enable goes inactive, the instruction is decoded.

After a read has been decoded, one more bus clock pulse arms the read-out. The stored word then leaves least significant bit first, one bit on the trailing edge of each later pulse. After a program instruction has been decoded, one more pulse starts a timed write cycle. During that cycle the busy line is active and the bus inputs are locked. A static strap inverts the active level of every bus line at once. A second strap selects an 8-bit or a 12-bit control word.

Top module: `serial_word_mem`

## Requirements
- R1: Every one of the 32 addresses keeps its own 16-bit word. A word that has been programmed reads back unchanged, whatever was written to other addresses.
- R2: The control word is 8 bits when the width strap is low and 12 bits when it is high. An instruction is acted on only if the number of clock pulses during receive-enable is exactly the control-word length (read) or 16 plus that length (program).
- R3: Bits are shifted in LSB first on the leading edge of the clock while receive-enable is active. The trailing edge of receive-enable decodes the word. The fields are: bits 4:0 address, bit 5 start half, bits 7:6 instruction (01 read, 10 program), and in the 12-bit format bits 11:8 chip select. A chip select that differs from the chip-id input, or instruction 00 or 11, causes no read and no program.
- R4: After a read decode, the data-output enable goes high. The first further pulse arms the read. Each following pulse presents the next data bit on the trailing edge of the clock, starting with the LSB.
- R5: When the start-half bit is 1, read-out begins at bit 8 of the word. Positions past bit 15 read as 0. A read may stop after any number of bits without affecting later operations.
- R6: For a program, the 16 data bits (LSB first) precede the control word. The trailing edge of one further pulse starts the cycle. Busy is then active for exactly PROG_CYCLES system clocks, after which the word is stored.
- R7: While busy is active, the receive-enable, clock and data inputs have no effect on the stored data, on the cycle length or on the state after the cycle.
- R8: An active reset during a program cycle ends it at once. Busy drops and the addressed word keeps its old value.
- R9: When the invert strap is high, the active level of receive-enable, clock, data in, data out and busy is low. When the strap is low, it is high.
- R10: The data-output enable is low after reset, low while busy and low outside a decoded read. It is never high together with busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, also aborts a program cycle |
| inv_strap | input | 1 | Static strap; high makes every bus line active low |
| wide_strap | input | 1 | Static strap; high selects the 12-bit control word |
| chip_id | input | 4 | Chip address compared with the select field of a 12-bit control word |
| bus_clk | input | 1 | Serial shift clock line |
| bus_din | input | 1 | Serial data input line |
| bus_rec | input | 1 | Receive-enable line |
| bus_dout | output | 1 | Serial data output line |
| bus_dout_oe | output | 1 | Output enable for bus_dout (models the high-impedance state) |
| bus_busy | output | 1 | Busy/load line, active during a program cycle |

## Verification
A wrong entry count or a wrong field decode shows up right after receive-enable falls. The output enable stays low, or busy never rises, within four system clocks. A misaligned read shift register or a wrong start offset corrupts the very first bit of the read. A program timer that is off by one changes the measured busy width. A cycle that is not locked, or an abort that still writes, only appears at the next read of that address, so every such case is followed by a read-back.

// File: rtl/swm_pkg.sv
package swm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ENTRY,
    ST_ARM_RD,
    ST_READ,
    ST_ARM_PG,
    ST_PROG
  } swm_state_t;

  localparam logic [1:0] OP_READ = 2'b01;
  localparam logic [1:0] OP_PROG = 2'b10;
endpackage

// File: rtl/swm_line_sync.sv
module swm_line_sync #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inv,
  input  logic [N-1:0] pins,
  output logic [N-1:0] lvl
);
  logic [N-1:0] stage1, stage2;
  logic [N-1:0] stage1_n;

  always_comb stage1_n = pins ^ {N{inv}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= stage1_n;
      stage2 <= stage1;
    end
  end

  assign lvl = stage2;
endmodule

// File: rtl/swm_edge.sv
module swm_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= lvl;
  end

  for (genvar i = 0; i < N; i++) begin : g_edge
    assign rise[i] = lvl[i] & ~prev[i];
    assign fall[i] = ~lvl[i] & prev[i];
  end
endmodule

// File: rtl/swm_entry_shift.sv
module swm_entry_shift #(
  parameter int DATA_W = 16,
  parameter int CW_N   = 8,
  parameter int CW_W   = 12,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              shift,
  input  logic              bit_in,
  input  logic              wide,
  output logic [CW_W-1:0]   ctrl,
  output logic [DATA_W-1:0] data,
  output logic [CNT_W-1:0]  count
);
  logic [CW_W-1:0]   ctrl_sr, ctrl_sr_n;
  logic [DATA_W-1:0] data_sr, data_sr_n;
  logic [CNT_W-1:0]  cnt, cnt_n;
  logic              spill;

  // bit leaving the control window moves into the data register
  assign spill = wide ? ctrl_sr[0] : ctrl_sr[CW_W-CW_N];

  always_comb begin
    ctrl_sr_n = ctrl_sr;
    data_sr_n = data_sr;
    cnt_n     = cnt;
    if (clear) begin
      ctrl_sr_n = '0;
      data_sr_n = '0;
      cnt_n     = '0;
    end else if (shift) begin
      ctrl_sr_n = {bit_in, ctrl_sr[CW_W-1:1]};
      data_sr_n = {spill, data_sr[DATA_W-1:1]};
      cnt_n     = (cnt == '1) ? cnt : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_sr <= '0;
      data_sr <= '0;
      cnt     <= '0;
    end else begin
      ctrl_sr <= ctrl_sr_n;
      data_sr <= data_sr_n;
      cnt     <= cnt_n;
    end
  end

  assign ctrl  = wide ? ctrl_sr : CW_W'(ctrl_sr[CW_W-1:CW_W-CW_N]);
  assign data  = data_sr;
  assign count = cnt;
endmodule

// File: rtl/swm_word_store.sv
module swm_word_store #(
  parameter int WORDS  = 32,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] cells [WORDS];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
  end

  assign rdata = cells[addr];
endmodule

// File: rtl/serial_word_mem.sv
module serial_word_mem
  import swm_pkg::*;
#(
  parameter int WORDS       = 32,
  parameter int DATA_W      = 16,
  parameter int CS_W        = 4,
  parameter int PROG_CYCLES = 40
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            inv_strap,
  input  logic            wide_strap,
  input  logic [CS_W-1:0] chip_id,
  input  logic            bus_clk,
  input  logic            bus_din,
  input  logic            bus_rec,
  output logic            bus_dout,
  output logic            bus_dout_oe,
  output logic            bus_busy
);
  localparam int ADDR_W = $clog2(WORDS);
  localparam int CW_N   = ADDR_W + 3;
  localparam int CW_W   = CW_N + CS_W;
  localparam int CNT_W  = $clog2(DATA_W + CW_W + 2);
  localparam int PC_W   = $clog2(PROG_CYCLES + 1);
  localparam int HALF   = DATA_W / 2;

  // synchronised, polarity-corrected lines: [2]=rec [1]=clk [0]=din
  logic [2:0] lvl;
  logic [1:0] rise, fall;
  logic       rec_rise, rec_fall, clk_rise, clk_fall;

  swm_line_sync #(.N(3)) u_sync (
    .clk(clk), .rst_n(rst_n), .inv(inv_strap),
    .pins({bus_rec, bus_clk, bus_din}), .lvl(lvl)
  );

  swm_edge #(.N(2)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(lvl[2:1]), .rise(rise), .fall(fall)
  );

  assign rec_rise = rise[1];
  assign rec_fall = fall[1];
  assign clk_rise = rise[0];
  assign clk_fall = fall[0];

  // entry shifter
  logic              sh_clear, sh_shift;
  logic [CW_W-1:0]   cw;
  logic [DATA_W-1:0] sh_data;
  logic [CNT_W-1:0]  sh_count;

  swm_entry_shift #(.DATA_W(DATA_W), .CW_N(CW_N), .CW_W(CW_W), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .clear(sh_clear), .shift(sh_shift), .bit_in(lvl[0]),
    .wide(wide_strap), .ctrl(cw), .data(sh_data), .count(sh_count)
  );

  // control word fields
  logic [ADDR_W-1:0] f_addr;
  logic              f_half;
  logic [1:0]        f_op;
  logic              f_sel;
  logic [CNT_W-1:0]  cw_len;

  assign f_addr = cw[ADDR_W-1:0];
  assign f_half = cw[ADDR_W];
  assign f_op   = cw[CW_N-1:CW_N-2];
  assign f_sel  = !wide_strap || (cw[CW_W-1:CW_N] == chip_id);
  assign cw_len = wide_strap ? CNT_W'(CW_W) : CNT_W'(CW_N);

  // state
  swm_state_t        st, st_n;
  logic [PC_W-1:0]   pcnt, pcnt_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic              half_q, half_n;
  logic [DATA_W-1:0] wdat_q, wdat_n;
  logic [DATA_W-1:0] osr, osr_n;
  logic              dout_q, dout_n;
  logic              we;
  logic [DATA_W-1:0] rd_word;

  swm_word_store #(.WORDS(WORDS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .we(we), .addr(addr_q), .wdata(wdat_q), .rdata(rd_word)
  );

  always_comb begin
    st_n     = st;
    pcnt_n   = pcnt;
    addr_n   = addr_q;
    half_n   = half_q;
    wdat_n   = wdat_q;
    osr_n    = osr;
    dout_n   = dout_q;
    we       = 1'b0;
    sh_clear = 1'b0;
    sh_shift = 1'b0;
    if (st == ST_PROG) begin
      if (pcnt == '0) begin
        we   = 1'b1;
        st_n = ST_IDLE;
      end else begin
        pcnt_n = pcnt - 1'b1;
      end
    end else if (rec_rise) begin
      sh_clear = 1'b1;
      dout_n   = 1'b0;
      st_n     = ST_ENTRY;
    end else begin
      unique case (st)
        ST_ENTRY: begin
          if (rec_fall) begin
            st_n = ST_IDLE;
            if (f_sel && f_op == OP_READ && sh_count == cw_len) begin
              st_n   = ST_ARM_RD;
              addr_n = f_addr;
              half_n = f_half;
            end else if (f_sel && f_op == OP_PROG &&
                         sh_count == cw_len + CNT_W'(DATA_W)) begin
              st_n   = ST_ARM_PG;
              addr_n = f_addr;
              wdat_n = sh_data;
            end
          end else if (clk_rise) begin
            sh_shift = 1'b1;
          end
        end
        ST_ARM_RD: if (clk_fall) begin
          osr_n = half_q ? (rd_word >> HALF) : rd_word;
          st_n  = ST_READ;
        end
        ST_READ: if (clk_fall) begin
          dout_n = osr[0];
          osr_n  = {1'b0, osr[DATA_W-1:1]};
        end
        ST_ARM_PG: if (clk_fall) begin
          pcnt_n = PC_W'(PROG_CYCLES - 1);
          st_n   = ST_PROG;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      pcnt   <= '0;
      addr_q <= '0;
      half_q <= 1'b0;
      wdat_q <= '0;
      osr    <= '0;
      dout_q <= 1'b0;
    end else begin
      st     <= st_n;
      pcnt   <= pcnt_n;
      addr_q <= addr_n;
      half_q <= half_n;
      wdat_q <= wdat_n;
      osr    <= osr_n;
      dout_q <= dout_n;
    end
  end

  assign bus_dout_oe = (st == ST_ARM_RD) || (st == ST_READ);
  assign bus_dout    = dout_q ^ inv_strap;
  assign bus_busy    = (st == ST_PROG) ^ inv_strap;
endmodule

// File: rtl/swm_checker.sv
module swm_checker #(
  parameter int PROG_CYCLES = 40
) (
  input logic clk,
  input logic rst_n,
  input logic inv_strap,
  input logic bus_rec,
  input logic bus_dout,
  input logic bus_dout_oe,
  input logic bus_busy
);
  localparam int RUN_W = $clog2(PROG_CYCLES + 2);

  logic busy_act, rec_act;
  logic [RUN_W-1:0] run;

  assign busy_act = bus_busy ^ inv_strap;
  assign rec_act  = bus_rec ^ inv_strap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run <= '0;
    else if (busy_act) run <= (run == '1) ? run : run + 1'b1;
    else               run <= '0;
  end

  p_busy_oe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_act && bus_dout_oe));

  p_oe_after_rec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_dout_oe) |-> !rec_act);

  p_busy_after_rec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_act) |-> !rec_act);

  p_busy_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_act) |-> run == RUN_W'(PROG_CYCLES));

  p_busy_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    run <= RUN_W'(PROG_CYCLES));

  p_dout_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_act |-> $stable(bus_dout));
endmodule

bind serial_word_mem swm_checker #(.PROG_CYCLES(PROG_CYCLES)) u_swm_chk (
  .clk(clk), .rst_n(rst_n), .inv_strap(inv_strap), .bus_rec(bus_rec),
  .bus_dout(bus_dout), .bus_dout_oe(bus_dout_oe), .bus_busy(bus_busy)
);

// File: tb/tb_serial_word_mem.sv
`timescale 1ns/1ps
module tb_serial_word_mem;
  localparam int PROG_CYCLES = 40;
  localparam logic [1:0] OPR = 2'b01;
  localparam logic [1:0] OPP = 2'b10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inv = 1'b0, wide = 1'b0;
  logic [3:0] cid = 4'h0;
  logic clk_a = 1'b0, din_a = 1'b0, rec_a = 1'b0;
  logic bus_dout, bus_dout_oe, bus_busy;
  logic busy_l;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  serial_word_mem #(.PROG_CYCLES(PROG_CYCLES)) dut (
    .clk(clk), .rst_n(rst_n), .inv_strap(inv), .wide_strap(wide), .chip_id(cid),
    .bus_clk(clk_a ^ inv), .bus_din(din_a ^ inv), .bus_rec(rec_a ^ inv),
    .bus_dout(bus_dout), .bus_dout_oe(bus_dout_oe), .bus_busy(bus_busy)
  );

  assign busy_l = bus_busy ^ inv;

  function automatic logic [15:0] pat(input int a);
    return 16'(a * 40503 + 4660) ^ 16'(a << 9);
  endfunction

  function automatic logic [11:0] mk_cw(input logic [1:0] op, input logic half,
                                        input logic [4:0] a, input logic [3:0] cs);
    return {cs, op, half, a};
  endfunction

  function automatic int cwlen();
    return wide ? 12 : 8;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_c(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic pulse();
    clk_a = 1'b1; wait_c(4); clk_a = 1'b0; wait_c(4);
  endtask

  task automatic send(input logic [31:0] bits, input int n);
    rec_a = 1'b1; wait_c(4);
    for (int i = 0; i < n; i++) begin
      din_a = bits[i]; wait_c(2); pulse();
    end
    rec_a = 1'b0; din_a = 1'b0; wait_c(5);
  endtask

  task automatic measure(output int w);
    w = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (busy_l) w++;
      else if (w > 0) break;
    end
  endtask

  task automatic start_pulse();
    clk_a = 1'b1; wait_c(4); clk_a = 1'b0;
  endtask

  task automatic do_prog(input logic [4:0] a, input logic [15:0] d, input logic [3:0] cs,
                         input int n, output int w);
    send({4'h0, mk_cw(OPP, 1'b0, a, cs), d}, n);
    start_pulse();
    measure(w);
    wait_c(3);
  endtask

  task automatic do_read(input logic [4:0] a, input logic half, input logic [3:0] cs,
                         input int n, input int nbits, output logic [15:0] w, output logic oe);
    send({20'h0, mk_cw(OPR, half, a, cs)}, n);
    @(negedge clk); oe = bus_dout_oe;
    pulse();
    w = '0;
    for (int i = 0; i < nbits; i++) begin
      pulse(); @(negedge clk); w[i] = bus_dout ^ inv;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; wait_c(2); @(negedge clk); rst_n = 1'b1; wait_c(3);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int w;
    logic [15:0] rd;
    logic oe;
    wait_c(3); @(negedge clk); rst_n = 1'b1; wait_c(3);

    // R10 reset state
    @(negedge clk);
    check("R10 oe after reset", bus_dout_oe, 0);
    check("R9 busy pin idle, inv low", bus_busy, 0);

    // R1/R6 narrow format, program every address
    for (int a = 0; a < 32; a++) begin
      do_prog(5'(a), pat(a), 4'h0, 24, w);
      if (a == 0) check("R6 busy width", w, PROG_CYCLES);
    end
    // R1/R4 read every address back
    for (int a = 0; a < 32; a++) begin
      do_read(5'(a), 1'b0, 4'h0, 8, 16, rd, oe);
      if (a == 3) check("R4 oe after read decode", oe, 1);
      check("R1 R4 readback", rd, pat(a));
    end
    @(negedge clk);
    check("R10 busy/oe exclusive during read", {busy_l, bus_dout_oe}, 2'b01);

    // R5 start at upper half, partial and overrun reads
    do_read(5'd5, 1'b1, 4'h0, 8, 8, rd, oe);
    check("R5 upper half", rd, {8'h0, pat(5)[15:8]});
    do_read(5'd6, 1'b1, 4'h0, 8, 12, rd, oe);
    check("R5 past bit 15 zero", rd, {8'h0, pat(6)[15:8]});
    do_read(5'd7, 1'b0, 4'h0, 8, 3, rd, oe);
    check("R5 stop early", rd, {13'h0, pat(7)[2:0]});
    do_read(5'd8, 1'b0, 4'h0, 8, 16, rd, oe);
    check("R5 after early stop", rd, pat(8));
    @(negedge clk);
    send(32'h0, 0);
    @(negedge clk);
    check("R10 oe low after new entry", bus_dout_oe, 0);

    // R2 wrong pulse counts
    send({20'h0, mk_cw(OPR, 1'b0, 5'd2, 4'h0)}, 7);
    @(negedge clk); check("R2 seven bits ignored", bus_dout_oe, 0);
    send({20'h0, mk_cw(OPR, 1'b0, 5'd2, 4'h0)}, 9);
    @(negedge clk); check("R2 nine bits ignored", bus_dout_oe, 0);
    do_prog(5'd2, 16'hDEAD, 4'h0, 23, w);
    check("R2 short program no busy", w, 0);
    do_read(5'd2, 1'b0, 4'h0, 8, 16, rd, oe);
    check("R2 short program no write", rd, pat(2));

    // R3 unknown instructions
    send({20'h0, mk_cw(2'b11, 1'b0, 5'd2, 4'h0)}, 8);
    @(negedge clk); check("R3 op 11 no read", bus_dout_oe, 0);
    send({20'h0, mk_cw(2'b00, 1'b0, 5'd2, 4'h0)}, 8);
    @(negedge clk); check("R3 op 00 no read", bus_dout_oe, 0);

    // R9 inverted polarity, R2 wide format, R3 chip select
    @(negedge clk); rst_n = 1'b0; inv = 1'b1; wide = 1'b1; cid = 4'hA;
    wait_c(2); @(negedge clk); rst_n = 1'b1; wait_c(3);
    @(negedge clk);
    check("R9 busy pin idle, inv high", bus_busy, 1);
    check("R9 dout pin idle, inv high", bus_dout, 1);
    do_prog(5'd7, 16'h1357, 4'hA, 28, w);
    check("R9 R6 busy width inverted", w, PROG_CYCLES);
    do_read(5'd7, 1'b0, 4'hA, 12, 16, rd, oe);
    check("R9 R2 wide readback", rd, 16'h1357);
    do_prog(5'd7, 16'hFFFF, 4'h5, 28, w);
    check("R3 chip mismatch no busy", w, 0);
    do_read(5'd7, 1'b0, 4'h5, 12, 0, rd, oe);
    check("R3 chip mismatch no read", oe, 0);
    send({20'h0, mk_cw(OPR, 1'b0, 5'd7, 4'hA)}, 8);
    @(negedge clk); check("R2 short word in wide mode", bus_dout_oe, 0);
    do_read(5'd7, 1'b0, 4'hA, 12, 16, rd, oe);
    check("R3 mismatch left word", rd, 16'h1357);

    // R7 bus locked while busy
    send({4'h0, mk_cw(OPP, 1'b0, 5'd9, 4'hA), 16'hBEEF}, 28);
    start_pulse();
    fork
      measure(w);
      begin
        wait_c(6); rec_a = 1'b1; wait_c(2); din_a = 1'b1; pulse();
        din_a = 1'b0; pulse(); rec_a = 1'b0;
      end
    join
    check("R7 busy width under activity", w, PROG_CYCLES);
    wait_c(3);
    do_read(5'd9, 1'b0, 4'hA, 12, 16, rd, oe);
    check("R7 word stored despite activity", rd, 16'hBEEF);

    // R8 reset aborts the program cycle
    send({4'h0, mk_cw(OPP, 1'b0, 5'd9, 4'hA), 16'h0F0F}, 28);
    start_pulse();
    for (int i = 0; i < 100 && !busy_l; i++) @(negedge clk);
    check("R8 busy started", busy_l, 1);
    wait_c(10);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R8 busy dropped at reset", busy_l, 0);
    @(negedge clk); rst_n = 1'b1; wait_c(3);
    do_read(5'd9, 1'b0, 4'hA, 12, 16, rd, oe);
    check("R8 aborted word unchanged", rd, 16'hBEEF);
    do_read(5'd31, 1'b1, 4'hA, 12, 8, rd, oe);
    check("R1 R5 last address upper half", rd, {8'h0, pat(31)[15:8]});

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule